// File: doc/BRIEF.md
# Change-of-Flow Cycle Sequencer

This block decides how long a jump, branch or subroutine call holds the pipeline of a wide-issue DSP core and then enforces that hold. When a change-of-flow operation issues, the block receives its class, whether it is the delayed variant, whether a conditional one is taken, the longest cycle count among the operations grouped with it in the same execution set, and the cycle length of its delay slot. It may also receive a flag saying that the target execution set straddles two fetch sets.

From these inputs it derives the number of cycles the flow change occupies. That number includes the extra cycle a call needs when its parallel group and delay slot use up the idle cycle normally spent pushing the return address and status. It also includes the minimum clamps of the delayed forms and the second fetch of a split target. A down-counter then holds a stall output and drops issue readiness until the occupancy has run out. The number of cycles of the operation accepted last is presented on an output.

Top module: `cof_sequencer`

## Requirements
- R1: After reset, `stall` is 0, `issue_ready` is 1 and `flow_cycles` is 0.
- R2: Class code 0 (jump) occupies 3 cycles; its delayed form occupies 3 minus the slot length, but no fewer than 1.
- R3: Class code 1 (jump to subroutine) occupies 3 cycles, plus 1 when the group length is 3 or more; its delayed form occupies 1 plus the group length.
- R4: Class code 2 (branch) occupies 4 cycles; its delayed form occupies 4 minus the slot length, but no fewer than 1.
- R5: Class code 3 (branch to subroutine) occupies 4 cycles, plus 1 when the group length is 4 or more. Its delayed form occupies 4 minus the slot length, raised to a floor. The floor is 1 plus the group length when group plus slot is below 4, and 2 otherwise.
- R6: Class code 4 (conditional jump or branch) occupies 1 cycle when not taken. When taken it occupies 4 cycles, and its delayed form occupies 4 minus the slot length, no fewer than 1.
- R7: When the delayed flag is 0, the slot length input has no effect on the cycle count.
- R8: A set split-target flag adds one cycle whenever control actually transfers (classes 0 to 3, or class 4 taken); it has no effect on a not-taken conditional.
- R9: Class codes 5 to 7 are reserved and occupy 1 cycle regardless of the other inputs.
- R10: An issue is accepted when `issue_valid` and `issue_ready` are both 1. For a count of N, `stall` is 1 and `issue_ready` is 0 for the N-1 cycles after the accepting edge. Both are released in the last of the N cycles, so the next issue can be accepted back to back.
- R11: `issue_valid` while `issue_ready` is 0 has no effect on the count in progress or on `flow_cycles`.
- R12: `flow_cycles` shows the cycle count of the last accepted issue from the edge that accepts it until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| issue_valid | input | 1 | A change-of-flow operation is presented |
| issue_ready | output | 1 | The sequencer can accept an operation this cycle |
| cof_class | input | 3 | Class code: 0 jump, 1 jump to subroutine, 2 branch, 3 branch to subroutine, 4 conditional, 5-7 reserved |
| cof_delayed | input | 1 | Delayed variant with a delay slot |
| cof_taken | input | 1 | Condition outcome, used by class 4 only |
| grp_cyc | input | 3 | Largest cycle count among operations grouped with it |
| slot_cyc | input | 3 | Cycle length of the delay slot |
| split_tgt | input | 1 | Target execution set spans two fetch sets |
| stall | output | 1 | Pipeline hold |
| flow_cycles | output | 4 | Cycle count of the last accepted operation |

## Verification
All outputs are registered. `flow_cycles`, `stall` and `issue_ready` all change at the rising edge that accepts an issue, and `stall` then falls at the edge that brings the count down to 1, N-1 edges after acceptance. The bench drives inputs on the falling edge, advances its reference counter at the following rising edge, and compares every output at the next falling edge. Each comparison therefore sees exactly one edge's worth of register updates. During stalls the bench keeps `issue_valid` high with altered fields, so that any leak of an ignored issue appears in the following cycle's comparison.

// File: rtl/cof_pkg.sv
package cof_pkg;
  typedef enum logic [2:0] {
    COF_JMP = 3'd0,
    COF_JSR = 3'd1,
    COF_BRA = 3'd2,
    COF_BSR = 3'd3,
    COF_CND = 3'd4
  } cof_cls_e;
endpackage

// File: rtl/cof_len_calc.sv
module cof_len_calc #(
  parameter int CW = 3,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic [2:0]    cls,
  input  logic          delayed,
  input  logic          taken,
  input  logic [CW-1:0] grp,
  input  logic [CW-1:0] slot,
  input  logic          split,
  output logic [LW-1:0] len
);
  import cof_pkg::*;

  localparam int SW = CW + 3;

  logic signed [SW-1:0] cjn_s, cd_s, base, floor_v, pick, raw;
  logic                 xfer;

  always_comb begin
    cjn_s   = {{(SW-CW){1'b0}}, grp};
    cd_s    = delayed ? {{(SW-CW){1'b0}}, slot} : '0;
    base    = SW'(1);
    floor_v = SW'(1);
    xfer    = 1'b1;
    case (cls)
      COF_JMP: base = SW'(3) - cd_s;
      COF_JSR: begin
        if (delayed) base = SW'(1) + cjn_s;
        else         base = (cjn_s >= SW'(3)) ? SW'(4) : SW'(3);
      end
      COF_BRA: base = SW'(4) - cd_s;
      COF_BSR: begin
        if (delayed) begin
          base    = SW'(4) - cd_s;
          floor_v = ((cjn_s + cd_s) < SW'(4)) ? (SW'(1) + cjn_s) : SW'(2);
        end else begin
          base = (cjn_s >= SW'(4)) ? SW'(5) : SW'(4);
        end
      end
      COF_CND: begin
        xfer = taken;
        base = taken ? (SW'(4) - cd_s) : SW'(1);
      end
      default: xfer = 1'b0;
    endcase
    pick = (base > floor_v) ? base : floor_v;
    raw  = pick + ((split && xfer) ? SW'(1) : SW'(0));
    len  = raw[LW-1:0];
  end

  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> (len != '0));
  assert_not_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && cls == 3'd4 && !taken) |-> (len == LW'(1)));
  assert_jump_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && cls == 3'd0 && !delayed) |-> (len == LW'(3) + LW'(split)));
  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && cls > 3'd4) |-> (len == LW'(1)));
endmodule

// File: rtl/cof_counter.sv
module cof_counter #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] len,
  output logic          stall,
  output logic          ready
);
  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = len;
    else if (cnt_q != '0)  cnt_d = cnt_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign stall = (cnt_q > LW'(1));
  assign ready = !stall;

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(len)));
  assert_countdown_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !load) |=> (cnt_q == $past(cnt_q) - LW'(1)));
  assert_no_load_in_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !load);
endmodule

// File: rtl/cof_sequencer.sv
module cof_sequencer #(
  parameter int CW = 3,
  parameter int LW = $clog2((1 << CW) + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  output logic          issue_ready,
  input  logic [2:0]    cof_class,
  input  logic          cof_delayed,
  input  logic          cof_taken,
  input  logic [CW-1:0] grp_cyc,
  input  logic [CW-1:0] slot_cyc,
  input  logic          split_tgt,
  output logic          stall,
  output logic [LW-1:0] flow_cycles
);
  logic          accept;
  logic [LW-1:0] len;
  logic [LW-1:0] flow_q, flow_d;

  assign accept = issue_valid && issue_ready;

  cof_len_calc #(.CW(CW), .LW(LW)) u_calc (
    .clk     (clk),
    .rst_n   (rst_n),
    .chk_en  (issue_valid),
    .cls     (cof_class),
    .delayed (cof_delayed),
    .taken   (cof_taken),
    .grp     (grp_cyc),
    .slot    (slot_cyc),
    .split   (split_tgt),
    .len     (len)
  );

  cof_counter #(.LW(LW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .len   (len),
    .stall (stall),
    .ready (issue_ready)
  );

  always_comb begin
    flow_d = flow_q;
    if (accept) flow_d = len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flow_q <= '0;
    else        flow_q <= flow_d;
  end

  assign flow_cycles = flow_q;

  assert_flow_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(flow_cycles));
  assert_flow_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (flow_cycles == $past(len)));
endmodule

// File: tb/sim_cof_sequencer.sv
module sim_cof_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue_valid = 1'b0;
  logic       issue_ready;
  logic [2:0] cof_class = '0;
  logic       cof_delayed = 1'b0;
  logic       cof_taken = 1'b0;
  logic [2:0] grp_cyc = '0;
  logic [2:0] slot_cyc = '0;
  logic       split_tgt = 1'b0;
  logic       stall;
  logic [3:0] flow_cycles;

  int    n_run = 0;
  int    n_fail = 0;
  int    m_cnt = 0;
  int    m_flow = 0;
  string m_tag = "R1";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  cof_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .cof_class(cof_class), .cof_delayed(cof_delayed), .cof_taken(cof_taken),
    .grp_cyc(grp_cyc), .slot_cyc(slot_cyc), .split_tgt(split_tgt),
    .stall(stall), .flow_cycles(flow_cycles)
  );

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int exp_len(int c, bit d, bit t, int gj, int sj, bit sp);
    int sl = d ? sj : 0;
    int n;
    bit moves = 1'b1;
    case (c)
      0: n = d ? max2(3 - sl, 1) : 3;
      1: n = d ? 1 + gj : ((gj >= 3) ? 4 : 3);
      2: n = d ? max2(4 - sl, 1) : 4;
      3: n = d ? max2(4 - sl, ((gj + sl) < 4) ? 1 + gj : 2) : ((gj >= 4) ? 5 : 4);
      4: begin moves = t; n = t ? (d ? max2(4 - sl, 1) : 4) : 1; end
      default: begin moves = 1'b0; n = 1; end
    endcase
    if (sp && moves) n++;
    return n;
  endfunction

  function automatic string req_tag(int c, bit d, bit t, int sj, bit sp);
    string s;
    case (c)
      0: s = "R2";
      1: s = "R3";
      2: s = "R4";
      3: s = "R5";
      4: s = "R6";
      default: s = "R9";
    endcase
    if (!d && sj != 0) s = {s, " R7"};
    if (sp && c < 5 && !(c == 4 && !t)) s = {s, " R8"};
    return {s, " R12"};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    int ms = (m_cnt > 1) ? 1 : 0;
    check(stall == ms[0], "R10 stall", int'(stall), ms);
    check(issue_ready == !ms[0], "R10 R11 issue_ready", int'(issue_ready), 1 - ms);
    check(int'(flow_cycles) == m_flow, m_tag, int'(flow_cycles), m_flow);
  endtask

  task automatic step(bit v, int c, bit d, bit t, int gj, int sj, bit sp);
    bit acc;
    int n;
    issue_valid = v;
    cof_class   = 3'(c);
    cof_delayed = d;
    cof_taken   = t;
    grp_cyc     = 3'(gj);
    slot_cyc    = 3'(sj);
    split_tgt   = sp;
    acc = v && (m_cnt <= 1);
    n = exp_len(c, d, t, gj, sj, sp);
    @(posedge clk);
    if (acc) begin
      m_cnt  = n;
      m_flow = n;
      m_tag  = req_tag(c, d, t, sj, sp);
    end else if (m_cnt > 0) begin
      m_cnt--;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic issue(int c, bit d, bit t, int gj, int sj, bit sp);
    step(1'b1, c, d, t, gj, sj, sp);
    while (m_cnt > 1) step(1'b1, (c + 1) % 8, !d, !t, 7 - gj, 7 - sj, !sp);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(stall == 1'b0, "R1 stall", int'(stall), 0);
    check(issue_ready == 1'b1, "R1 issue_ready", int'(issue_ready), 1);
    check(flow_cycles == 4'd0, "R1 flow_cycles", int'(flow_cycles), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    // directed corners
    issue(0, 1'b1, 1'b0, 0, 7, 1'b0);  // R2 clamp to 1
    issue(1, 1'b0, 1'b0, 3, 0, 1'b0);  // R3 extra push cycle
    issue(1, 1'b1, 1'b0, 7, 0, 1'b1);  // R3 R8 longest
    issue(3, 1'b1, 1'b0, 1, 1, 1'b0);  // R5 group+slot below 4
    issue(3, 1'b1, 1'b0, 2, 3, 1'b0);  // R5 floor 2
    issue(4, 1'b0, 1'b0, 0, 0, 1'b1);  // R6 R8 not taken, split ignored
    issue(5, 1'b1, 1'b1, 7, 7, 1'b1);  // R9
    step(1'b0, 0, 1'b0, 1'b0, 0, 0, 1'b0);
    // exhaustive sweep with back-to-back issues and ignored valids in stalls
    for (int c = 0; c < 8; c++)
      for (int d = 0; d < 2; d++)
        for (int t = 0; t < 2; t++)
          for (int gj = 0; gj < 8; gj++)
            for (int sj = 0; sj < 8; sj++)
              for (int sp = 0; sp < 2; sp++) begin
                issue(c, d[0], t[0], gj, sj, sp[0]);
                if (sp == 1 && sj == 0) step(1'b0, 2, 1'b0, 1'b0, 0, 0, 1'b0);
              end
    repeat (12) step(1'b0, 0, 1'b0, 1'b0, 0, 0, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule